// File: doc/BRIEF.md
# Output Bin Drain with Time-Multiplexed Concentration

This block is the output side of a fully connected cell fabric. For one output line, every input owns a private single-cell holding register (a bin). The routing logic upstream is represented only by one write strobe per bin and a shared cell bus split into per-bin slices. During a slot, any subset of the bins may be loaded.

The block runs on a clock at least NUM_BINS+1 times faster than the cell slot rate. A one-cycle slot marker starts a scan on the next cycle. The scan visits the bins in ascending index order, one bin per cycle. An occupied bin is copied into a queue and emptied in the same cycle; an empty bin is passed over and adds nothing to the queue.

Each slot marker also releases one cell from the head of the queue onto the output line. When the queue is full, an arriving cell is discarded and a saturating counter records the loss. A bin that is loaded again before its earlier cell was taken raises a one-cycle overrun flag for that bin, and the bin keeps the newer cell.

Top module: `obin_drain`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `overrun`, `busy` and `drop_count` are all zero.
- R2: A high `bin_wr[b]` on a clock edge stores slice b of `bin_cells` (bits b*CELL_W upward) in bin b. The bin holds exactly one cell, and that cell stays until the scan takes it.
- R3: A `slot_pulse` sampled on edge E makes `busy` high for exactly NUM_BINS cycles after E. During that window bin k is visited on the edge E+1+k, for k running from 0 up to NUM_BINS-1.
- R4: When the scan visits an empty bin, nothing enters the queue.
- R5: A visited occupied bin is emptied as its cell enters the queue. If the bin is written on that same edge, it keeps the new cell and no overrun is flagged.
- R6: If a write hits a bin that holds a cell and that bin is not being visited on that edge, `overrun[b]` is high for the one following cycle and the bin then holds the new cell.
- R7: Cells leave on `out_cell` in the order in which they entered the queue. This order is bin index order within a slot, and slot order across slots.
- R8: A `slot_pulse` sampled while the queue is not empty makes `out_valid` high for exactly the next cycle, with the head cell on `out_cell`. Otherwise `out_valid` is low.
- R9: The queue holds FIFO_DEPTH cells. A cell that reaches a full queue is discarded and `drop_count` goes up by one. The count saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_pulse | input | 1 | One-cycle slot boundary marker |
| bin_wr | input | NUM_BINS | Per-bin load strobe |
| bin_cells | input | NUM_BINS*CELL_W | Per-bin cell data, slice b for bin b |
| out_valid | output | 1 | Output line cell valid, one cycle per slot |
| out_cell | output | CELL_W | Output line cell |
| overrun | output | NUM_BINS | Per-bin overrun flag, one cycle |
| busy | output | 1 | Scan in progress |
| drop_count | output | DROP_W | Saturating count of cells discarded at a full queue |

## Verification
The assertions assume that slot markers are spaced at least NUM_BINS+1 cycles apart. With that spacing, a new marker never arrives while a scan is still running, and the "scan ends after NUM_BINS cycles" property stays valid. The stimulus keeps every slot at 12 cycles. Bin writes are not restricted: they may land in any cycle, including cycles of the scan. This lets the same-edge write-and-drain case and the overrun case both occur. The long phase writes all eight bins in every slot, so the queue gains seven cells per slot. This drives the queue to full and pushes the discard counter past its saturation point.

// File: rtl/obin_pkg.sv
`timescale 1ns/1ps
package obin_pkg;
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/obin_scan.sv
`timescale 1ns/1ps
module obin_scan
   import obin_pkg::*;
#(
   parameter int NUM_BINS = 8,
   localparam int IDX_W = idx_bits(NUM_BINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                slot_pulse,
   output logic                busy,
   output logic [IDX_W-1:0]    idx,
   output logic [NUM_BINS-1:0] drain_sel
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

   scan_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SCAN_IDLE;
         idx   <= '0;
      end else if (slot_pulse) begin
         state <= SCAN_RUN;
         idx   <= '0;
      end else if (state == SCAN_RUN) begin
         if (idx == LAST_IDX) begin
            state <= SCAN_IDLE;
            idx   <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign busy = (state == SCAN_RUN);

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_sel
      assign drain_sel[b] = busy && (idx == IDX_W'(b));
   end

   // R3
   scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_pulse |=> (busy && idx == '0));
   // R3
   scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == LAST_IDX && !slot_pulse) |=> !busy);
   // R3
   scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != LAST_IDX && !slot_pulse) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/obin_bin_bank.sv
`timescale 1ns/1ps
module obin_bin_bank #(
   parameter int NUM_BINS = 8,
   parameter int CELL_W   = 16,
   localparam int FLAT_W  = NUM_BINS * CELL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_BINS-1:0] wr,
   input  logic [FLAT_W-1:0]   wr_cells,
   input  logic [NUM_BINS-1:0] drain_sel,
   output logic [NUM_BINS-1:0] held,
   output logic [FLAT_W-1:0]   held_cells,
   output logic [NUM_BINS-1:0] overrun
);
   for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      logic [CELL_W-1:0] cell_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held[b]    <= 1'b0;
            overrun[b] <= 1'b0;
         end else begin
            overrun[b] <= wr[b] && held[b] && !drain_sel[b];
            if (wr[b])
               held[b] <= 1'b1;
            else if (drain_sel[b])
               held[b] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr[b])
            cell_q <= wr_cells[b*CELL_W +: CELL_W];
      end

      assign held_cells[b*CELL_W +: CELL_W] = cell_q;

      // R2
      bin_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr[b] |=> (held[b] && held_cells[b*CELL_W +: CELL_W] == $past(wr_cells[b*CELL_W +: CELL_W])));
      // R5
      bin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (drain_sel[b] && !wr[b]) |=> !held[b]);
      // R6
      bin_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr[b] && held[b] && !drain_sel[b]) |=> overrun[b]);
   end
endmodule

// File: rtl/obin_fifo.sv
`timescale 1ns/1ps
module obin_fifo #(
   parameter int CELL_W     = 16,
   parameter int FIFO_DEPTH = 32,
   parameter int DROP_W     = 8,
   parameter bit SAT_DROP   = 1'b1,
   localparam int AW        = $clog2(FIFO_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [CELL_W-1:0] push_cell,
   input  logic              pop_req,
   output logic              out_valid,
   output logic [CELL_W-1:0] out_cell,
   output logic [DROP_W-1:0] drop_cnt
);
   localparam logic [AW:0] FULL_LVL = (AW+1)'(FIFO_DEPTH);

   logic [CELL_W-1:0] mem [FIFO_DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [AW:0]       level;
   logic              full, empty, accept, take;

   assign full   = (level == FULL_LVL);
   assign empty  = (level == '0);
   assign accept = push && !full;
   assign take   = pop_req && !empty;

   always_ff @(posedge clk) begin
      if (accept)
         mem[wr_ptr] <= push_cell;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         level     <= '0;
         out_valid <= 1'b0;
         out_cell  <= '0;
      end else begin
         out_valid <= take;
         if (take) begin
            out_cell <= mem[rd_ptr];
            rd_ptr   <= rd_ptr + 1'b1;
         end
         if (accept)
            wr_ptr <= wr_ptr + 1'b1;
         case ({accept, take})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   if (SAT_DROP) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)
            drop_cnt <= '0;
         else if (push && full && !(&drop_cnt))
            drop_cnt <= drop_cnt + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)
            drop_cnt <= '0;
         else if (push && full)
            drop_cnt <= drop_cnt + 1'b1;
      end
   end

   // R9
   drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (drop_cnt == DROP_W'($past(drop_cnt) + 1'b1) || (SAT_DROP && &$past(drop_cnt))));
   // R9
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full) |=> $stable(drop_cnt));
   // R8
   pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_req |=> !out_valid);
   // R8
   pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !empty) |=> out_valid);
endmodule

// File: rtl/obin_drain.sv
`timescale 1ns/1ps
module obin_drain
   import obin_pkg::*;
#(
   parameter int NUM_BINS   = 8,
   parameter int CELL_W     = 16,
   parameter int FIFO_DEPTH = 32,
   parameter int DROP_W     = 8,
   parameter bit SAT_DROP   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         slot_pulse,
   input  logic [NUM_BINS-1:0]          bin_wr,
   input  logic [NUM_BINS*CELL_W-1:0]   bin_cells,
   output logic                         out_valid,
   output logic [CELL_W-1:0]            out_cell,
   output logic [NUM_BINS-1:0]          overrun,
   output logic                         busy,
   output logic [DROP_W-1:0]            drop_count
);
   localparam int IDX_W  = idx_bits(NUM_BINS);
   localparam int FLAT_W = NUM_BINS * CELL_W;

   if (NUM_BINS < 2) begin : g_bad_bins
      $error("NUM_BINS must be at least 2");
   end
   if (CELL_W < 1) begin : g_bad_width
      $error("CELL_W must be positive");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("DROP_W must be positive");
   end

   logic [IDX_W-1:0]    scan_idx;
   logic [NUM_BINS-1:0] drain_sel;
   logic [NUM_BINS-1:0] held;
   logic [FLAT_W-1:0]   held_cells;
   logic [CELL_W-1:0]   cell_arr [NUM_BINS];
   logic                push;
   logic [CELL_W-1:0]   push_cell;

   obin_scan #(.NUM_BINS(NUM_BINS)) i_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_pulse (slot_pulse),
      .busy       (busy),
      .idx        (scan_idx),
      .drain_sel  (drain_sel)
   );

   obin_bin_bank #(.NUM_BINS(NUM_BINS), .CELL_W(CELL_W)) i_bins (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bin_wr),
      .wr_cells   (bin_cells),
      .drain_sel  (drain_sel),
      .held       (held),
      .held_cells (held_cells),
      .overrun    (overrun)
   );

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_unpack
      assign cell_arr[b] = held_cells[b*CELL_W +: CELL_W];
   end

   assign push      = |(drain_sel & held);
   assign push_cell = cell_arr[scan_idx];

   obin_fifo #(
      .CELL_W     (CELL_W),
      .FIFO_DEPTH (FIFO_DEPTH),
      .DROP_W     (DROP_W),
      .SAT_DROP   (SAT_DROP)
   ) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_cell (push_cell),
      .pop_req   (slot_pulse),
      .out_valid (out_valid),
      .out_cell  (out_cell),
      .drop_cnt  (drop_count)
   );

   // R3
   one_visit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drain_sel) && (busy == (drain_sel != '0)));
   // R4
   empty_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !held[scan_idx]) |-> !push);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !busy && overrun == '0 && drop_count == '0));
endmodule

// File: tb/test_obin_drain.sv
`timescale 1ns/1ps
module test_obin_drain;
   localparam int N  = 8;
   localparam int W  = 16;
   localparam int D  = 32;
   localparam int DW = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slot_pulse = 1'b0;
   logic [N-1:0]     bin_wr = '0;
   logic [N*W-1:0]   bin_cells = '0;
   logic             out_valid;
   logic [W-1:0]     out_cell;
   logic [N-1:0]     overrun;
   logic             busy;
   logic [DW-1:0]    drop_count;

   always #10 clk = ~clk;

   obin_drain #(.NUM_BINS(N), .CELL_W(W), .FIFO_DEPTH(D), .DROP_W(DW)) i_obin_drain (
      .clk(clk), .rst_n(rst_n), .slot_pulse(slot_pulse), .bin_wr(bin_wr),
      .bin_cells(bin_cells), .out_valid(out_valid), .out_cell(out_cell),
      .overrun(overrun), .busy(busy), .drop_count(drop_count)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string phase = "R1";

   // reference model state
   bit          mv [N];
   logic [W-1:0] md [N];
   logic [W-1:0] q [$];
   bit          m_busy = 0;
   int          m_idx = 0;
   bit          m_ov = 0;
   logic [W-1:0] m_oc = '0;
   logic [N-1:0] m_ovr = '0;
   int          m_drop = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (%s) %s: actual %0h expected %0h", req, phase, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(busy == m_busy, "R3", "busy", busy, m_busy);
      chk(overrun == m_ovr, "R6", "overrun", overrun, m_ovr);
      chk(out_valid == m_ov, "R8", "out_valid", out_valid, m_ov);
      if (m_ov) chk(out_cell == m_oc, "R7", "out_cell", out_cell, m_oc);
      chk(int'(drop_count) == m_drop, "R9", "drop_count", drop_count, m_drop);
   endtask

   task automatic model_step();
      bit cand = 0;
      logic [W-1:0] cd = '0;
      int di = -1;
      bit room;
      if (m_busy) begin
         di = m_idx;
         if (mv[di]) begin cand = 1; cd = md[di]; end
      end
      for (int b = 0; b < N; b++) m_ovr[b] = bin_wr[b] && mv[b] && (di != b);
      room = (q.size() < D);
      if (slot_pulse && q.size() > 0) begin m_ov = 1; m_oc = q.pop_front(); end
      else m_ov = 0;
      if (cand) begin
         if (room) q.push_back(cd);
         else if (m_drop < (1 << DW) - 1) m_drop++;
      end
      for (int b = 0; b < N; b++) begin
         if (bin_wr[b]) begin mv[b] = 1; md[b] = bin_cells[b*W +: W]; end
         else if (di == b) mv[b] = 0;
      end
      if (slot_pulse) begin m_busy = 1; m_idx = 0; end
      else if (m_busy) begin
         if (m_idx == N - 1) begin m_busy = 0; m_idx = 0; end
         else m_idx++;
      end
   endtask

   task automatic step(input bit p, input logic [N-1:0] w, input logic [N*W-1:0] d);
      @(negedge clk);
      compare();
      slot_pulse = p; bin_wr = w; bin_cells = d;
      @(posedge clk);
      #1 model_step();
   endtask

   function automatic logic [N*W-1:0] pattern(input int tag);
      logic [N*W-1:0] v;
      for (int b = 0; b < N; b++) v[b*W +: W] = W'(tag * 16 + b);
      return v;
   endfunction

   task automatic slot(input logic [N-1:0] w, input int tag);
      step(1'b1, '0, '0);
      for (int c = 0; c < 11; c++) step(1'b0, (c == 10) ? w : '0, pattern(tag));
   endtask

   initial begin
      for (int b = 0; b < N; b++) begin mv[b] = 0; md[b] = '0; end
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state on the ports
      chk(out_valid == 0 && busy == 0 && overrun == '0 && drop_count == '0,
          "R1", "reset outputs", {out_valid, busy, overrun, drop_count}, 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      step(1'b0, '0, '0);

      phase = "R2";  // sparse load, bins 1, 4, 6
      step(1'b0, 8'b0101_0010, pattern(1));
      phase = "R4";  // scan skips the five empty bins
      slot('0, 2);
      slot('0, 3);
      slot('0, 4);
      slot('0, 5);

      phase = "R5";  // write bin 3 on every scan cycle, same-edge drain included
      step(1'b0, 8'b0000_1000, pattern(6));
      step(1'b1, '0, '0);
      for (int c = 0; c < N; c++) step(1'b0, 8'b0000_1000, pattern(7 + c));
      for (int c = 0; c < 3; c++) step(1'b0, '0, '0);

      phase = "R6";  // double load of bin 2 outside a scan
      step(1'b0, 8'b0000_0100, pattern(20));
      step(1'b0, 8'b0000_0100, pattern(21));
      step(1'b0, '0, '0);
      slot('0, 22);
      slot('0, 23);

      phase = "R9";  // all bins every slot: queue fills, drops saturate
      for (int s = 0; s < 45; s++) slot('1, 30 + s);

      phase = "R7";  // drain the queue, order from the model
      for (int s = 0; s < 40; s++) slot('0, 0);

      phase = "R8";
      for (int c = 0; c < 4; c++) step(1'b0, '0, '0);
      @(negedge clk);
      compare();
      chk(out_valid == 0, "R8", "idle output", out_valid, 0);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(100000 * 20);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog (%s): actual running expected finished", phase);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule